// File: doc/BRIEF.md
# Legacy-Aware Bridge Transaction Router

This block sits in a host bridge and picks the destination of each memory or I/O request issued by the processor. Each request goes either to the graphics port or to the downstream hub interface. The decision uses the legacy display ranges: colour display memory and registers, and monochrome display memory and registers. It also honours holes cut into the I/O window for ISA address aliases, and the programmable I/O and memory base/limit windows. Traffic that no rule claims falls through to the hub interface.

A request is presented with `req_vld`, a memory/I-O flag and a 32-bit address. One clock later the block presents a registered, valid-tagged routing bit. The control inputs come from configuration registers held elsewhere. One of their combinations is not allowed, and the block flags it on a registered output.

Top module: `legacy_route_dec`

## Requirements
- R1: `rsp_vld` equals `req_vld` of the previous cycle. `rsp_to_gfx` is 1 for the graphics port and 0 for the hub interface. `rsp_to_gfx` is 0 whenever `rsp_vld` is 0.
- R2: While `rst_n` is low, and on the first cycle after its release, `rsp_vld`, `rsp_to_gfx` and `cfg_bad` are all 0.
- R3: With `vga_en`=1, a memory request with address in 0x000A0000..0x000BFFFF goes to the graphics port, whatever the memory window holds. The one exception is R6.
- R4: With `vga_en`=1, an I/O request whose address bits [9:0] are in 0x3B0..0x3BB or 0x3C0..0x3DF goes to the graphics port. Bits [31:10] are ignored, and `isa_en` and the I/O window have no effect. The one exception is R6.
- R5: With `vga_en`=1, an I/O request whose bits [9:0] are in 0x3BC..0x3BF goes to the hub interface. With `vga_en`=0, such a request follows R8/R9.
- R6: With `vga_en`=1 and `mda_en`=1, monochrome references go to the hub interface. These are memory 0x000B0000..0x000B7FFF, and I/O with bits [9:0] in 0x3B4..0x3B5 or 0x3B8..0x3BF.
- R7: With `vga_en`=0, legacy-range requests get no special treatment. They go to the graphics port only if a window covers them, and `mda_en` has no effect on the route.
- R8: An I/O request not claimed by R4–R6 goes to the graphics port when `io_lo` ≤ addr[15:0] ≤ `io_hi`. R9 can override this.
- R9: With `isa_en`=1, an I/O request inside the I/O window whose bits [9:8] are not 00 goes to the hub interface.
- R10: A memory request not claimed by R3/R6 goes to the graphics port when `mem_lo` ≤ addr ≤ `mem_hi`.
- R11: `cfg_bad` is 1 exactly one cycle after a cycle with `vga_en`=0 and `mda_en`=1, and 0 after any other combination.
- R12: A request that matches no rule goes to the hub interface.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request present this cycle |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr | input | 32 | Request address |
| vga_en | input | 1 | Legacy colour display decode enable |
| mda_en | input | 1 | Monochrome display present |
| isa_en | input | 1 | Cut ISA alias holes out of the I/O window |
| io_lo | input | 16 | I/O window lower bound (inclusive) |
| io_hi | input | 16 | I/O window upper bound (inclusive) |
| mem_lo | input | 32 | Memory window lower bound (inclusive) |
| mem_hi | input | 32 | Memory window upper bound (inclusive) |
| rsp_vld | output | 1 | Route decision valid |
| rsp_to_gfx | output | 1 | 1 = graphics port, 0 = hub interface |
| cfg_bad | output | 1 | Illegal control combination seen last cycle |

## Verification
The route bit and its valid pass through one register, so they appear one clock after the request. The illegal-configuration flag likewise reflects the control inputs of the previous clock. The bench changes every input on a falling edge and reads the outputs at the following falling edge. Exactly one rising edge lies between the two, and the inputs stay unchanged across that window, so the expected value is computed from the inputs still being driven. Idle cycles are checked the same way to confirm that valid drops and the route bit stays clear.

// File: rtl/lrd_pkg.sv
package lrd_pkg;

    typedef enum logic {
        DEST_HUB = 1'b0,
        DEST_GFX = 1'b1
    } lrd_dest_e;

    typedef struct packed {
        logic      vld;
        lrd_dest_e dest;
        logic      bad;
    } lrd_state_t;

    localparam logic [31:0] VGA_MEM_LO = 32'h000A_0000;
    localparam logic [31:0] VGA_MEM_HI = 32'h000B_FFFF;
    localparam logic [31:0] MON_MEM_LO = 32'h000B_0000;
    localparam logic [31:0] MON_MEM_HI = 32'h000B_7FFF;

    localparam logic [9:0] VGA_IO_A_LO = 10'h3B0;
    localparam logic [9:0] VGA_IO_A_HI = 10'h3BB;
    localparam logic [9:0] VGA_IO_B_LO = 10'h3C0;
    localparam logic [9:0] VGA_IO_B_HI = 10'h3DF;
    localparam logic [9:0] MON_IO_A_LO = 10'h3B4;
    localparam logic [9:0] MON_IO_A_HI = 10'h3B5;
    localparam logic [9:0] MON_IO_B_LO = 10'h3B8;
    localparam logic [9:0] MON_IO_B_HI = 10'h3BF;
    localparam logic [9:0] GAP_IO_LO   = 10'h3BC;
    localparam logic [9:0] GAP_IO_HI   = 10'h3BF;

endpackage

// File: rtl/lrd_window_match.sv
module lrd_window_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         hit
);
    always_comb begin
        hit = (value >= lo) && (value <= hi);
    end
endmodule

// File: rtl/lrd_legacy_match.sv
module lrd_legacy_match
    import lrd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              is_io,
    input  logic [ADDR_W-1:0] addr,
    output logic              vga_hit,
    output logic              mon_hit,
    output logic              gap_hit
);
    localparam int LEG_BITS = 10;

    logic [LEG_BITS-1:0] low_bits;
    logic vga_io, mon_io, vga_mem, mon_mem;

    always_comb begin
        low_bits = addr[LEG_BITS-1:0];
        vga_io  = ((low_bits >= VGA_IO_A_LO) && (low_bits <= VGA_IO_A_HI)) ||
                  ((low_bits >= VGA_IO_B_LO) && (low_bits <= VGA_IO_B_HI));
        mon_io  = ((low_bits >= MON_IO_A_LO) && (low_bits <= MON_IO_A_HI)) ||
                  ((low_bits >= MON_IO_B_LO) && (low_bits <= MON_IO_B_HI));
        vga_mem = (addr >= ADDR_W'(VGA_MEM_LO)) && (addr <= ADDR_W'(VGA_MEM_HI));
        mon_mem = (addr >= ADDR_W'(MON_MEM_LO)) && (addr <= ADDR_W'(MON_MEM_HI));
        vga_hit = is_io ? vga_io : vga_mem;
        mon_hit = is_io ? mon_io : mon_mem;
        gap_hit = is_io && (low_bits >= GAP_IO_LO) && (low_bits <= GAP_IO_HI);
    end
endmodule

// File: rtl/legacy_route_dec.sv
module legacy_route_dec
    import lrd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IO_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic              req_is_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              vga_en,
    input  logic              mda_en,
    input  logic              isa_en,
    input  logic [IO_W-1:0]   io_lo,
    input  logic [IO_W-1:0]   io_hi,
    input  logic [ADDR_W-1:0] mem_lo,
    input  logic [ADDR_W-1:0] mem_hi,
    output logic              rsp_vld,
    output logic              rsp_to_gfx,
    output logic              cfg_bad
);
    localparam int BLK_MSB = 9;
    localparam int BLK_LSB = 8;

    logic vga_hit, mon_hit, gap_hit;
    logic io_win_hit, mem_win_hit, isa_hole;
    lrd_state_t st_d, st_q;

    lrd_legacy_match #(.ADDR_W(ADDR_W)) u_legacy (
        .is_io   (req_is_io),
        .addr    (req_addr),
        .vga_hit (vga_hit),
        .mon_hit (mon_hit),
        .gap_hit (gap_hit)
    );

    lrd_window_match #(.W(IO_W)) u_io_win (
        .value (req_addr[IO_W-1:0]),
        .lo    (io_lo),
        .hi    (io_hi),
        .hit   (io_win_hit)
    );

    lrd_window_match #(.W(ADDR_W)) u_mem_win (
        .value (req_addr),
        .lo    (mem_lo),
        .hi    (mem_hi),
        .hit   (mem_win_hit)
    );

    always_comb begin
        isa_hole = isa_en && (req_addr[BLK_MSB:BLK_LSB] != 2'b00);
        st_d      = '0;
        st_d.vld  = req_vld;
        st_d.bad  = mda_en && !vga_en;
        st_d.dest = DEST_HUB;
        if (req_vld) begin
            if (vga_en && mda_en && mon_hit) begin
                st_d.dest = DEST_HUB;
            end else if (vga_en && gap_hit) begin
                st_d.dest = DEST_HUB;
            end else if (vga_en && vga_hit) begin
                st_d.dest = DEST_GFX;
            end else if (req_is_io) begin
                st_d.dest = (io_win_hit && !isa_hole) ? DEST_GFX : DEST_HUB;
            end else begin
                st_d.dest = mem_win_hit ? DEST_GFX : DEST_HUB;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_vld    = st_q.vld;
    assign rsp_to_gfx = (st_q.dest == DEST_GFX);
    assign cfg_bad    = st_q.bad;

endmodule

// File: rtl/lrd_checker.sv
module lrd_checker #(
    parameter int ADDR_W = 32,
    parameter int IO_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_vld,
    input logic              req_is_io,
    input logic [ADDR_W-1:0] req_addr,
    input logic              vga_en,
    input logic              mda_en,
    input logic              isa_en,
    input logic [IO_W-1:0]   io_lo,
    input logic [IO_W-1:0]   io_hi,
    input logic [ADDR_W-1:0] mem_lo,
    input logic [ADDR_W-1:0] mem_hi,
    input logic              rsp_vld,
    input logic              rsp_to_gfx,
    input logic              cfg_bad
);
    logic [9:0] lb;
    logic       io_in, mem_in;
    assign lb     = req_addr[9:0];
    assign io_in  = (req_addr[IO_W-1:0] >= io_lo) && (req_addr[IO_W-1:0] <= io_hi);
    assign mem_in = (req_addr >= mem_lo) && (req_addr <= mem_hi);

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_vld |-> !rsp_to_gfx);
    p_vga_io_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_is_io && vga_en && !mda_en && lb >= 10'h3C0 && lb <= 10'h3DF)
        |=> rsp_to_gfx);
    p_gap_hub_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_is_io && vga_en && lb >= 10'h3BC && lb <= 10'h3BF)
        |=> !rsp_to_gfx);
    p_mono_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_is_io && vga_en && mda_en &&
         req_addr >= ADDR_W'(32'h000B_0000) && req_addr <= ADDR_W'(32'h000B_7FFF))
        |=> !rsp_to_gfx);
    p_isa_hole_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_is_io && !vga_en && isa_en && req_addr[9:8] != 2'b00)
        |=> !rsp_to_gfx);
    p_io_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_is_io && !vga_en && !isa_en && io_in) |=> rsp_to_gfx);
    p_mem_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_is_io && !vga_en && mem_in) |=> rsp_to_gfx);
    p_bad_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mda_en && !vga_en) |=> cfg_bad);
    p_good_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mda_en && !vga_en) |=> !cfg_bad);
endmodule

bind legacy_route_dec lrd_checker #(.ADDR_W(ADDR_W), .IO_W(IO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_is_io(req_is_io),
    .req_addr(req_addr), .vga_en(vga_en), .mda_en(mda_en), .isa_en(isa_en),
    .io_lo(io_lo), .io_hi(io_hi), .mem_lo(mem_lo), .mem_hi(mem_hi),
    .rsp_vld(rsp_vld), .rsp_to_gfx(rsp_to_gfx), .cfg_bad(cfg_bad)
);

// File: tb/legacy_route_dec_tb.sv
module legacy_route_dec_tb;
    localparam int CLK_NS   = 10;
    localparam int N_RANDOM = 3000;
    localparam int WATCHDOG = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic        req_is_io = 1'b0;
    logic [31:0] req_addr = '0;
    logic        vga_en = 1'b0, mda_en = 1'b0, isa_en = 1'b0;
    logic [15:0] io_lo = '0, io_hi = '0;
    logic [31:0] mem_lo = '0, mem_hi = '0;
    logic        rsp_vld, rsp_to_gfx, cfg_bad;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    legacy_route_dec u_dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_is_io(req_is_io),
        .req_addr(req_addr), .vga_en(vga_en), .mda_en(mda_en), .isa_en(isa_en),
        .io_lo(io_lo), .io_hi(io_hi), .mem_lo(mem_lo), .mem_hi(mem_hi),
        .rsp_vld(rsp_vld), .rsp_to_gfx(rsp_to_gfx), .cfg_bad(cfg_bad)
    );

    function automatic bit in_rng(input logic [31:0] v, input logic [31:0] lo, input logic [31:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

    // Expected destination from the requirements; tag names the deciding rule.
    function automatic bit exp_gfx(output string tag);
        logic [31:0] lb;
        bit mono, vga, gap;
        lb   = {22'd0, req_addr[9:0]};
        mono = req_is_io ? (in_rng(lb, 32'h3B4, 32'h3B5) || in_rng(lb, 32'h3B8, 32'h3BF))
                         : in_rng(req_addr, 32'h000B0000, 32'h000B7FFF);
        vga  = req_is_io ? (in_rng(lb, 32'h3B0, 32'h3BB) || in_rng(lb, 32'h3C0, 32'h3DF))
                         : in_rng(req_addr, 32'h000A0000, 32'h000BFFFF);
        gap  = req_is_io && in_rng(lb, 32'h3BC, 32'h3BF);
        if (vga_en && mda_en && mono) begin tag = "R6"; return 1'b0; end
        if (vga_en && gap)            begin tag = "R5"; return 1'b0; end
        if (vga_en && vga)            begin tag = req_is_io ? "R4" : "R3"; return 1'b1; end
        if (req_is_io) begin
            if (in_rng({16'd0, req_addr[15:0]}, {16'd0, io_lo}, {16'd0, io_hi})) begin
                if (isa_en && req_addr[9:8] != 2'b00) begin tag = "R9"; return 1'b0; end
                tag = "R8"; return 1'b1;
            end
            tag = "R12"; return 1'b0;
        end
        if (in_rng(req_addr, mem_lo, mem_hi)) begin tag = "R10"; return 1'b1; end
        tag = "R12";
        return 1'b0;
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b (io=%0b addr=%h vga=%0b mda=%0b isa=%0b)",
                     req, what, act, exp, req_is_io, req_addr, vga_en, mda_en, isa_en);
        end
    endtask

    // Inputs change at a falling edge; outputs read at the next falling edge.
    task automatic send(input bit io, input logic [31:0] a, input string note);
        string tag;
        bit    e;
        req_vld   = 1'b1;
        req_is_io = io;
        req_addr  = a;
        @(negedge clk);
        e = exp_gfx(tag);
        check("R1", "valid", rsp_vld, 1'b1);
        check(tag, note, rsp_to_gfx, e);
        check("R11", "cfg flag", cfg_bad, mda_en && !vga_en);
    endtask

    task automatic idle();
        req_vld  = 1'b0;
        req_addr = 32'h000A_0000;
        @(negedge clk);
        check("R1", "idle valid", rsp_vld, 1'b0);
        check("R1", "idle route", rsp_to_gfx, 1'b0);
    endtask

    task automatic set_cfg(input bit v, input bit m, input bit i);
        vga_en = v; mda_en = m; isa_en = i;
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        // R2: reset holds outputs low while a request is offered.
        req_vld = 1'b1; req_is_io = 1'b0; req_addr = 32'h000A_0000;
        set_cfg(1'b0, 1'b1, 1'b0);
        mem_lo = 32'h0; mem_hi = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R2", "reset valid", rsp_vld, 1'b0);
        check("R2", "reset route", rsp_to_gfx, 1'b0);
        check("R2", "reset flag", cfg_bad, 1'b0);
        req_vld = 1'b0;
        set_cfg(1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", "first valid", rsp_vld, 1'b0);
        check("R2", "first flag", cfg_bad, 1'b0);

        // Directed corners.
        io_lo = 16'h1000; io_hi = 16'h1FFF;
        mem_lo = 32'h1000_0000; mem_hi = 32'h1FFF_FFFF;
        set_cfg(1'b1, 1'b0, 1'b1);
        send(1'b0, 32'h000A_0000, "R3 low edge");
        send(1'b0, 32'h000B_FFFF, "R3 high edge");
        send(1'b0, 32'h000C_0000, "R12 above legacy");
        send(1'b1, 32'hABCD_F7B0, "R4 alias low");
        send(1'b1, 32'h0000_03DF, "R4 top");
        send(1'b1, 32'h0000_13C4, "R4 over isa hole");
        send(1'b1, 32'h0000_03BC, "R5 gap low");
        send(1'b1, 32'h0000_FFBF, "R5 gap alias");
        send(1'b1, 32'h0000_03E0, "R12 past vga");
        idle();
        set_cfg(1'b1, 1'b1, 1'b0);
        send(1'b0, 32'h000B_0000, "R6 mono mem low");
        send(1'b0, 32'h000B_7FFF, "R6 mono mem high");
        send(1'b0, 32'h000B_8000, "R3 colour after mono");
        send(1'b1, 32'h0000_07B4, "R6 mono io alias");
        send(1'b1, 32'h0000_03B6, "R4 vga between mono");
        set_cfg(1'b0, 1'b0, 1'b0);
        send(1'b1, 32'h0000_03BD, "R7 gap no vga hub");
        io_lo = 16'h0000; io_hi = 16'h0FFF;
        send(1'b1, 32'h0000_03BD, "R7 gap via window");
        send(1'b1, 32'h0000_03C0, "R7 vga via window");
        send(1'b1, 32'h0000_1000, "R12 above io window");
        isa_en = 1'b1;
        send(1'b1, 32'h0000_0100, "R9 hole start");
        send(1'b1, 32'h0000_04FF, "R8 lower quarter");
        send(1'b1, 32'h0000_0400, "R8 block start");
        mda_en = 1'b1;
        send(1'b0, 32'h000B_0000, "R7 mono ignored");
        idle();
        check("R11", "flag after illegal", cfg_bad, 1'b1);
        mda_en = 1'b0;
        send(1'b0, 32'h1000_0000, "R10 window low");
        send(1'b0, 32'h1FFF_FFFF, "R10 window high");
        send(1'b0, 32'h0FFF_FFFF, "R12 below window");

        // Constrained random stimulus.
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [31:0] a;
            bit io;
            int sel;
            set_cfg(1'($urandom), 1'($urandom), 1'($urandom));
            io_lo  = 16'($urandom);
            io_hi  = (io_lo > 16'hC000) ? 16'hFFFF : io_lo + 16'($urandom % 32'h4000);
            mem_lo = $urandom % 32'h0020_0000;
            mem_hi = mem_lo + ($urandom % 32'h0008_0000);
            io  = 1'($urandom);
            sel = int'($urandom % 3);
            if (io) begin
                a = $urandom;
                if (sel != 0) a[9:0] = 10'h3A0 + 10'($urandom % 32'h50);
                if (sel == 2) a[31:16] = '0;
            end else begin
                a = (sel == 0) ? $urandom : 32'h0009_8000 + ($urandom % 32'h0003_0000);
            end
            if ($urandom % 8 == 0) idle();
            send(io, a, "random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule